// File: doc/BRIEF.md
# Multicycle Controller-Datapath Processor

This block is a compact 16-bit processor split into a control state machine and a datapath. The datapath holds a program counter, an instruction register, a sixteen-entry register file with one write port and two gated read ports, and a single ALU that adds, subtracts or passes its first operand through while it raises a zero flag. The processor reaches one external word-addressed memory through a single port with separate read and write strobes. The memory reads combinationally within the cycle and writes on the clock edge.

Each instruction runs as a short sequence of single-cycle states. A fetch cycle reads the word at the program counter into the instruction register and steps the counter. A decode cycle picks the execute state from the top four bits of the instruction. One execute cycle then does the work and hands control back to fetch. The seven defined operations cover loads and stores at a direct address, a store through a register pointer, a load of a small constant, wrapping add and subtract, and a conditional jump that fires when a register holds zero.

Top module: `fsmd_cpu`

## Requirements
- R1: While rst_n is low at a clock edge, the program counter is cleared to 0, every register is cleared to 0 and the machine enters the fetch state. Right after reset, mem_addr is 0, mem_re is 1 and mem_we is 0.
- R2: A fetch cycle drives mem_addr with the program counter and asserts mem_re. It loads the instruction register from mem_rdata and adds 1 to the program counter. The following cycle is decode, and a defined operation executes in the third cycle, so the next fetch comes three cycles after the previous one.
- R3: Instruction fields: opcode is bits [15:12], the first register index rn is bits [11:8], the second register index rm is bits [7:4], and the 8-bit address, constant or jump target is bits [7:0]. Each 8-bit field is zero-extended to 16 bits.
- R4: Opcode 0x0 loads register rn from the memory word at the zero-extended 8-bit address.
- R5: Opcode 0x1 writes register rn to the memory word at the zero-extended 8-bit address.
- R6: Opcode 0x2 writes register rm to the memory word whose address is the content of register rn.
- R7: Opcode 0x3 loads register rn with the zero-extended 8-bit constant.
- R8: Opcode 0x4 sets rn to rn + rm modulo 2^16. No carry is kept.
- R9: Opcode 0x5 sets rn to rn - rm modulo 2^16. No borrow is kept.
- R10: Opcode 0x6 loads the program counter with the zero-extended 8-bit target when register rn is zero. Otherwise the counter keeps the value already incremented in fetch.
- R11: Opcodes 0x7 to 0xF change no register and no memory word, and the next fetch follows the decode cycle directly (two cycles per such instruction).
- R12: mem_re and mem_we are never both high. mem_we is high only in the execute cycle of a store (opcode 0x1 or 0x2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Word address for the external memory |
| mem_wdata | output | 16 | Data to be written to memory |
| mem_rdata | input | 16 | Data read from memory, valid in the same cycle |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe, taken at the clock edge |

## Verification
The assertions check the sequencing on every cycle: fetch is always followed by decode and every execute state returns to fetch. They also check that the program counter steps by exactly one on fetch, that a taken jump lands on its target while an untaken one leaves the counter alone, that a register write lands at the addressed entry, and that the memory strobes never overlap. The bench scenarios are the only way to show that the arithmetic results and their wrap-around are correct, that the field slicing and zero extension are right, and that a reserved opcode leaves registers and memory alone. Only the scenarios can also show that reset wipes register contents and that the measured cycle spacing between fetches matches three and two cycles.

// File: rtl/fsmd_pkg.sv
// Shared encodings for the multicycle processor: states, ALU operations,
// the two datapath mux selects and the bundle of control strobes.
// Assumes 16-bit instructions with the opcode in the top nibble.
package fsmd_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_LDDIR,
        ST_STDIR,
        ST_STIND,
        ST_LDIMM,
        ST_ADD,
        ST_SUB,
        ST_JZ
    } cpu_state_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_PASS = 2'd2
    } alu_op_e;

    // register-file write source
    typedef enum logic [1:0] {
        WSEL_ALU = 2'd0,
        WSEL_MEM = 2'd1,
        WSEL_IMM = 2'd2
    } wsel_e;

    // memory address source
    typedef enum logic [1:0] {
        ASEL_PC  = 2'd0,
        ASEL_DIR = 2'd1,
        ASEL_RF  = 2'd2
    } asel_e;

    typedef struct packed {
        logic    ir_ld;
        logic    pc_inc;
        logic    pc_ld;
        logic    rf_we;
        logic    rf_r1e;
        logic    rf_r2e;
        logic    r2_uses_rn;
        logic    mem_re;
        logic    mem_we;
        alu_op_e alu_op;
        wsel_e   wsel;
        asel_e   asel;
    } ctrl_t;

endpackage

// File: rtl/fsmd_regfile.sv
// Register file: one synchronous write port and two combinational read
// ports. A read port with its enable low returns zero. Every entry is
// cleared by the synchronous active-low reset.
module fsmd_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          r1e,
    input  logic [AW-1:0] r1a,
    output logic [DW-1:0] rd1,
    input  logic          r2e,
    input  logic [AW-1:0] r2a,
    output logic [DW-1:0] rd2
);

    logic [DW-1:0] regs [NREG];

    // storage update: clear on reset, else single-port write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    // gated read ports
    always_comb begin
        rd1 = r1e ? regs[r1a] : '0;
        rd2 = r2e ? regs[r2a] : '0;
    end

    // R4, R7, R8, R9: a requested write is visible at its entry next cycle
    a_r4_rf_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/fsmd_alu.sv
// Single ALU: wrapping add, wrapping subtract, or pass of operand a.
// The zero flag reflects the result and drives the conditional jump.
module fsmd_alu
    import fsmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          zero
);

    // operation select, result truncated to DW bits
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = a;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/fsmd_ctrl.sv
// Controller: state register plus next-state and strobe decoding.
// Fetch -> decode -> one execute state -> fetch; reserved opcodes go
// straight from decode back to fetch. Assumes a combinational memory read.
module fsmd_ctrl
    import fsmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_zero,
    output cpu_state_e       st,
    output ctrl_t            ctl
);

    cpu_state_e st_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_FETCH;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = ST_FETCH;
        if (st == ST_FETCH) begin
            st_nxt = ST_DECODE;
        end else if (st == ST_DECODE) begin
            case (opcode)
                4'h0:    st_nxt = ST_LDDIR;
                4'h1:    st_nxt = ST_STDIR;
                4'h2:    st_nxt = ST_STIND;
                4'h3:    st_nxt = ST_LDIMM;
                4'h4:    st_nxt = ST_ADD;
                4'h5:    st_nxt = ST_SUB;
                4'h6:    st_nxt = ST_JZ;
                default: st_nxt = ST_FETCH;
            endcase
        end
    end

    // control strobes per state
    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_PASS;
        ctl.wsel   = WSEL_ALU;
        ctl.asel   = ASEL_PC;
        case (st)
            ST_FETCH: begin
                ctl.mem_re = 1'b1;
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            ST_LDDIR: begin
                ctl.asel   = ASEL_DIR;
                ctl.mem_re = 1'b1;
                ctl.wsel   = WSEL_MEM;
                ctl.rf_we  = 1'b1;
            end
            ST_STDIR: begin
                ctl.asel       = ASEL_DIR;
                ctl.rf_r2e     = 1'b1;
                ctl.r2_uses_rn = 1'b1;
                ctl.mem_we     = 1'b1;
            end
            ST_STIND: begin
                ctl.asel   = ASEL_RF;
                ctl.rf_r1e = 1'b1;
                ctl.rf_r2e = 1'b1;
                ctl.mem_we = 1'b1;
            end
            ST_LDIMM: begin
                ctl.wsel  = WSEL_IMM;
                ctl.rf_we = 1'b1;
            end
            ST_ADD, ST_SUB: begin
                ctl.rf_r1e = 1'b1;
                ctl.rf_r2e = 1'b1;
                ctl.alu_op = (st == ST_ADD) ? ALU_ADD : ALU_SUB;
                ctl.rf_we  = 1'b1;
            end
            ST_JZ: begin
                ctl.rf_r1e = 1'b1;
                ctl.pc_ld  = alu_zero;
            end
            default: ;
        endcase
    end

    // R2: fetch is always followed by decode
    a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_FETCH |=> st == ST_DECODE);

    // R11: every execute state hands back to fetch
    a_r11_exec_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_FETCH && st != ST_DECODE) |=> st == ST_FETCH);

endmodule

// File: rtl/fsmd_cpu.sv
// Top of the multicycle processor: program counter, instruction register,
// address and write-back muxes, wired to the controller, register file
// and ALU. Expects a single-port memory that reads combinationally.
module fsmd_cpu
    import fsmd_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 16,
    parameter int REG_CNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic              mem_we
);

    localparam int RA_W  = $clog2(REG_CNT);
    localparam int FLD_W = 8;

    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] ir;
    cpu_state_e        st;
    ctrl_t             ctl;
    logic [RA_W-1:0]   rn, rm, r2a;
    logic [ADDR_W-1:0] fld_addr;
    logic [DATA_W-1:0] fld_data;
    logic [DATA_W-1:0] rd1, rd2, rf_wdata, alu_y;
    logic              alu_zero;

    // field slicing and zero extension
    always_comb begin
        rn       = RA_W'(ir[11:8]);
        rm       = RA_W'(ir[7:4]);
        fld_addr = {{(ADDR_W-FLD_W){1'b0}}, ir[FLD_W-1:0]};
        fld_data = {{(DATA_W-FLD_W){1'b0}}, ir[FLD_W-1:0]};
        r2a      = ctl.r2_uses_rn ? rn : rm;
    end

    // program counter and instruction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else begin
            if (ctl.ir_ld)  ir <= mem_rdata;
            if (ctl.pc_inc) pc <= pc + 1'b1;
            else if (ctl.pc_ld) pc <= fld_addr;
        end
    end

    // memory address mux and strobes
    always_comb begin
        case (ctl.asel)
            ASEL_DIR: mem_addr = fld_addr;
            ASEL_RF:  mem_addr = ADDR_W'(rd1);
            default:  mem_addr = pc;
        endcase
        mem_wdata = rd2;
        mem_re    = ctl.mem_re;
        mem_we    = ctl.mem_we;
    end

    // register-file write-back mux
    always_comb begin
        case (ctl.wsel)
            WSEL_MEM: rf_wdata = mem_rdata;
            WSEL_IMM: rf_wdata = fld_data;
            default:  rf_wdata = alu_y;
        endcase
    end

    fsmd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (ir[15:12]),
        .alu_zero (alu_zero),
        .st       (st),
        .ctl      (ctl)
    );

    fsmd_regfile #(.NREG(REG_CNT), .DW(DATA_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.rf_we),
        .waddr (rn),
        .wdata (rf_wdata),
        .r1e   (ctl.rf_r1e),
        .r1a   (rn),
        .rd1   (rd1),
        .r2e   (ctl.rf_r2e),
        .r2a   (r2a),
        .rd2   (rd2)
    );

    fsmd_alu #(.DW(DATA_W)) u_alu (
        .op   (ctl.alu_op),
        .a    (rd1),
        .b    (rd2),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // R2: fetch advances the program counter by exactly one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> pc == $past(pc) + 1'b1);

    // R10: a taken jump lands on the zero-extended target
    a_r10_jz_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_ld |=> pc == $past(fld_addr));

    // R10: an untaken jump leaves the counter unchanged
    a_r10_jz_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_JZ && rd1 != '0) |=> $stable(pc));

    // R12: read and write strobes never overlap
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

endmodule

// File: tb/test_fsmd_cpu.sv
// Bench: small memory model, a vector table of add/subtract operand pairs
// run through one program, then directed programs for the remaining forms.
module test_fsmd_cpu;

    localparam int CLK_P   = 10;
    localparam int NVEC    = 6;
    localparam int RUN_CYC = 40;

    // operand pairs {a, b}; expectations computed below
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0003, 16'h0005},
        {16'hFFFF, 16'h0001},
        {16'h0000, 16'h0001},
        {16'h8000, 16'h8000},
        {16'h1234, 16'h1234},
        {16'hA5A5, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_re, mem_we;
    logic [15:0] mem [256];
    int          n_chk = 0;
    int          n_err = 0;
    int          n_overlap = 0;
    int          n_badwe = 0;
    logic        done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fsmd_cpu i_fsmd_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_we    (mem_we)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    // memory write and strobe monitor (R12)
    always @(posedge clk) begin
        if (rst_n && mem_re && mem_we) n_overlap++;
        if (rst_n && mem_we && mem_re) n_badwe++;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // hold reset, wait for in-flight writes, clear memory
    task automatic begin_prog();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int a = 0; a < 256; a++) mem[a] = 16'h0000;
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        // R1, R2: reset state and three-cycle fetch spacing
        begin_prog();
        mem[0] = 16'h3105;            // load constant into r1
        mem[1] = 16'h6001;            // spin: jump-if-zero r0 to 1
        release_reset();
        check("R1 reset mem_addr", mem_addr, 16'h0000);
        check("R1 reset mem_re", {15'd0, mem_re}, 16'h0001);
        check("R1 reset mem_we", {15'd0, mem_we}, 16'h0000);
        run(3);
        check("R2 next fetch addr", mem_addr, 16'h0001);
        check("R2 next fetch re", {15'd0, mem_re}, 16'h0001);

        // R8, R9, R4, R5, R3: vector table through one program
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] va, vb;
            va = VEC[v][31:16];
            vb = VEC[v][15:0];
            begin_prog();
            mem[0] = 16'h0180;        // r1 <- [0x80]
            mem[1] = 16'h0281;        // r2 <- [0x81]
            mem[2] = 16'h4120;        // r1 <- r1 + r2
            mem[3] = 16'h1182;        // [0x82] <- r1
            mem[4] = 16'h0380;        // r3 <- [0x80]
            mem[5] = 16'h5320;        // r3 <- r3 - r2
            mem[6] = 16'h1383;        // [0x83] <- r3
            mem[7] = 16'h6007;        // spin
            mem[8'h80] = va;
            mem[8'h81] = vb;
            release_reset();
            run(RUN_CYC);
            check("R8 add wrap", mem[8'h82], 16'(va + vb));
            check("R9 sub wrap", mem[8'h83], 16'(va - vb));
            check("R4 load kept source", mem[8'h80], va);
        end

        // R6, R7, R11: indirect store, constant zero-extend, reserved opcodes
        begin_prog();
        mem[0] = 16'h3490;            // r4 <- 0x90
        mem[1] = 16'h355A;            // r5 <- 0x5A
        mem[2] = 16'h2450;            // [r4] <- r5
        mem[3] = 16'h36FF;            // r6 <- 0x00FF
        mem[4] = 16'h1691;            // [0x91] <- r6
        mem[5] = 16'h7ABC;            // reserved
        mem[6] = 16'hF000;            // reserved
        mem[7] = 16'h1695;            // [0x95] <- r6
        mem[8] = 16'h1A96;            // [0x96] <- r10
        mem[9] = 16'h6009;            // spin
        mem[8'hBC] = 16'h7777;
        mem[8'h96] = 16'h1111;
        release_reset();
        run(RUN_CYC);
        check("R6 indirect store", mem[8'h90], 16'h005A);
        check("R7 constant zero-extended", mem[8'h91], 16'h00FF);
        check("R11 reserved kept register", mem[8'h95], 16'h00FF);
        check("R11 reserved left rn alone", mem[8'h96], 16'h0000);
        check("R11 reserved no memory write", mem[8'hBC], 16'h7777);

        // R11: reserved opcode takes two cycles to the next fetch
        begin_prog();
        mem[0] = 16'hF000;
        mem[1] = 16'h6001;
        release_reset();
        run(2);
        check("R11 two-cycle spacing addr", mem_addr, 16'h0001);
        check("R11 two-cycle spacing re", {15'd0, mem_re}, 16'h0001);

        // R10: untaken then taken jump
        begin_prog();
        mem[0]     = 16'h3701;        // r7 <- 1
        mem[1]     = 16'h6730;        // r7 != 0: not taken
        mem[2]     = 16'h6020;        // r0 == 0: taken to 0x20
        mem[3]     = 16'h1793;        // skipped
        mem[8'h20] = 16'h1792;        // [0x92] <- r7
        mem[8'h21] = 16'h6021;        // spin
        mem[8'h30] = 16'h1794;        // reached only on wrong jump
        mem[8'h93] = 16'hDEAD;
        mem[8'h94] = 16'hBEEF;
        release_reset();
        run(RUN_CYC);
        check("R10 taken target reached", mem[8'h92], 16'h0001);
        check("R10 fallthrough skipped", mem[8'h93], 16'hDEAD);
        check("R10 untaken did not jump", mem[8'h94], 16'hBEEF);

        // R1: reset clears register contents; R5 store direct of a register
        begin_prog();
        mem[0] = 16'h3942;            // r9 <- 0x42
        mem[1] = 16'h1998;            // [0x98] <- r9
        mem[2] = 16'h6002;
        release_reset();
        run(RUN_CYC);
        check("R5 direct store", mem[8'h98], 16'h0042);
        begin_prog();
        mem[0] = 16'h1997;            // [0x97] <- r9
        mem[1] = 16'h6001;
        mem[8'h97] = 16'h5555;
        release_reset();
        run(RUN_CYC);
        check("R1 registers cleared", mem[8'h97], 16'h0000);

        // R12: strobe overlap never seen
        check("R12 strobes exclusive", 16'(n_overlap), 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule